// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one PCI function and serves a single configuration access port. A request carries a byte offset into the 256-byte configuration space, a byte count (1, 2 or 4), a write flag and little-endian write data. Reads return the little-endian bytes that start at the offset, one cycle later. Everything from the end of the header to the end of configuration space is an unimplemented device-specific area that reads as zero and swallows writes.

The header identity fields (vendor, device, revision, class, subsystem, interrupt pin, grant and latency limits) are fixed by parameters. Software can change only the command, status, cache line size, latency timer and interrupt line fields, the six base address registers and the expansion ROM base. Each base address register responds to an all-ones size probe with its size mask. It never loses its I/O-or-memory type bits. The ROM base has its own probe value. Each BAR size parameter must be zero (BAR unused) or a power of two.

Top module: `pci_cfg_header`

## Requirements
- R1: After reset the header holds the parameter values: vendor at 0x00, device at 0x02, command at 0x04, status at 0x06, revision at 0x08, the 24-bit class code at 0x09..0x0B, header type at 0x0E, BARs at 0x10+4n (n = 0..5), subsystem vendor at 0x2C, subsystem id at 0x2E, ROM base at 0x30, capability pointer at 0x34, interrupt pin/min grant/max latency at 0x3D/0x3E/0x3F. Cache line size (0x0C), latency timer (0x0D), interrupt line (0x3C), BIST (0x0F), 0x28..0x2B and the reserved bytes 0x35..0x3B read zero.
- R2: A read with req_size 1, 2 or 4 (the value is the byte count) raises rd_valid exactly one cycle later. rd_data then holds the requested bytes with the byte at the offset in bits 7:0, and unrequested upper bytes are zero. Bytes at offsets 0x40 and above within a read that starts inside the header read as zero.
- R3: Reads anywhere in 0x40..0xFF return zero. Writes there change nothing and raise no error.
- R4: A 4-byte write of 0xFFFFFFFF to BAR n stores the inverse of (size−1), with the type bits kept from the old value, so a size-0 BAR reads back its type bits only.
- R5: Any other 4-byte BAR write keeps bits 1:0 of the old value if its bit 0 is 1 (I/O) or bits 3:0 if bit 0 is 0 (memory), and takes all other bits from the write data.
- R6: A 4-byte write of 0xFFFFFFFE to 0x30 stores 0xFFFFFFFF. Any other value is stored unchanged.
- R7: A 1-byte write updates 0x0C, 0x0D or 0x3C. A 1-byte write to 0x08, 0x0B, 0x3D, 0x3E or 0x3F is ignored without error. A 1-byte write to any other header offset raises err.
- R8: A 2-byte write at 0x04 sets command, at 0x06 sets status, and at 0x0C sets cache line size from bits 7:0 only (latency timer unchanged). Any other header offset raises err.
- R9: A 4-byte write at 0x04 sets command from bits 15:0 and leaves status unchanged. 4-byte writes to header offsets other than 0x04, 0x30 and the BARs are ignored without error.
- R10: A request with req_size other than 1, 2 or 4 raises err one cycle later for one cycle, gives no rd_valid and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 8 | Byte offset in configuration space |
| req_size | input | 3 | Access size in bytes (1, 2, 4 legal) |
| req_wdata | input | 32 | Little-endian write data |
| rd_valid | output | 1 | Read data valid, one cycle after a legal read |
| rd_data | output | 32 | Little-endian read data |
| err | output | 1 | One-cycle pulse for an illegal size or forbidden write |

## Verification
The port accepts one request every cycle. A read's response can therefore be on the outputs in the same cycle as a write to the same register is being captured, and a read can be accepted in the cycle right after the write that changes it. The bench runs read-write-read sequences back to back on a BAR, the command register and the ROM base, with no idle cycles between them. A behavioural byte-array model, updated in request order, predicts every cycle's rd_valid, rd_data and err. It expects the first read to return the old value and the read right after the write to return the new one.

// File: rtl/pci_cfg_header.sv
module pci_cfg_header #(
  parameter logic [15:0]  VENDOR_ID   = 16'hC0DE,
  parameter logic [15:0]  DEVICE_ID   = 16'h7A11,
  parameter logic [15:0]  CMD_INIT    = 16'h0000,
  parameter logic [15:0]  STATUS_INIT = 16'h0010,
  parameter logic [7:0]   REVISION    = 8'h03,
  parameter logic [23:0]  CLASS_CODE  = 24'h020000,
  parameter logic [7:0]   HDR_TYPE    = 8'h00,
  parameter logic [15:0]  SUB_VENDOR  = 16'hC0DE,
  parameter logic [15:0]  SUB_ID      = 16'h0042,
  parameter logic [7:0]   CAP_PTR     = 8'h00,
  parameter logic [31:0]  ROM_INIT    = 32'h0,
  parameter logic [7:0]   INT_PIN     = 8'h01,
  parameter logic [7:0]   MIN_GNT     = 8'h02,
  parameter logic [7:0]   MAX_LAT     = 8'h08,
  parameter int           NUM_BARS    = 6,
  parameter logic [191:0] BAR_INIT    = {32'h0, 32'h1, 32'h0, 32'h8, 32'h1, 32'h0},
  parameter logic [191:0] BAR_SIZES   = {32'h0, 32'h20, 32'h0, 32'h10000, 32'h100, 32'h1000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_off,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        err
);
  localparam int HDR_BYTES = 64;
  localparam int HDR_BITS  = 8 * HDR_BYTES;
  localparam int BAR_BASE  = 16;

  logic [15:0]  cmd_q, sts_q;
  logic [7:0]   cls_q, lat_q, intl_q;
  logic [31:0]  rom_q;
  logic [31:0]  bar_q    [NUM_BARS];
  logic [31:0]  bar_keep [NUM_BARS];
  logic [31:0]  bar_next [NUM_BARS];
  logic [HDR_BITS-1:0] hdr_flat;
  logic [31:0]  rd_comb;
  logic         legal, in_hdr, rd_ok, wr1, wr2, wr4, wr_bad;

  assign legal  = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  assign in_hdr = req_off < 8'(HDR_BYTES);
  assign rd_ok  = req_valid && !req_write && legal;
  assign wr1    = req_valid && req_write && in_hdr && (req_size == 3'd1);
  assign wr2    = req_valid && req_write && in_hdr && (req_size == 3'd2);
  assign wr4    = req_valid && req_write && in_hdr && (req_size == 3'd4);

  always_comb begin
    wr_bad = 1'b0;
    if (wr1)
      case (req_off)
        8'h0C, 8'h0D, 8'h3C, 8'h08, 8'h0B, 8'h3D, 8'h3E, 8'h3F: wr_bad = 1'b0;
        default: wr_bad = 1'b1;
      endcase
    if (wr2)
      case (req_off)
        8'h04, 8'h06, 8'h0C: wr_bad = 1'b0;
        default: wr_bad = 1'b1;
      endcase
  end

  assign hdr_flat = {MAX_LAT, MIN_GNT, INT_PIN, intl_q, 56'h0, CAP_PTR, rom_q,
                     SUB_ID, SUB_VENDOR, 32'h0,
                     bar_q[5], bar_q[4], bar_q[3], bar_q[2], bar_q[1], bar_q[0],
                     8'h00, HDR_TYPE, lat_q, cls_q, CLASS_CODE, REVISION,
                     sts_q, cmd_q, DEVICE_ID, VENDOR_ID};

  always_comb begin
    rd_comb = '0;
    for (int k = 0; k < 4; k++)
      if (k < int'(req_size) && (int'(req_off) + k) < HDR_BYTES)
        rd_comb[8*k +: 8] = hdr_flat[8*((int'(req_off) + k) % HDR_BYTES) +: 8];
  end

  always_comb begin
    for (int i = 0; i < NUM_BARS; i++) begin
      bar_keep[i] = bar_q[i][0] ? 32'h3 : 32'hF;
      bar_next[i] = (((req_wdata == 32'hFFFF_FFFF) ? ~(BAR_SIZES[32*i +: 32] - 32'd1)
                                                   : req_wdata) & ~bar_keep[i])
                    | (bar_q[i] & bar_keep[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= CMD_INIT;
      sts_q    <= STATUS_INIT;
      cls_q    <= '0;
      lat_q    <= '0;
      intl_q   <= '0;
      rom_q    <= ROM_INIT;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      err      <= 1'b0;
      for (int i = 0; i < NUM_BARS; i++) bar_q[i] <= BAR_INIT[32*i +: 32];
    end else begin
      rd_valid <= rd_ok;
      err      <= req_valid && (!legal || wr_bad);
      if (rd_ok) rd_data <= rd_comb;
      if (wr1)
        case (req_off)
          8'h0C: cls_q  <= req_wdata[7:0];
          8'h0D: lat_q  <= req_wdata[7:0];
          8'h3C: intl_q <= req_wdata[7:0];
          default: ;
        endcase
      if (wr2)
        case (req_off)
          8'h04: cmd_q <= req_wdata[15:0];
          8'h06: sts_q <= req_wdata[15:0];
          8'h0C: cls_q <= req_wdata[7:0];
          default: ;
        endcase
      if (wr4) begin
        if (req_off == 8'h04) cmd_q <= req_wdata[15:0];
        if (req_off == 8'h30) rom_q <= (req_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : req_wdata;
        for (int i = 0; i < NUM_BARS; i++)
          if (req_off == 8'(BAR_BASE + 4*i)) bar_q[i] <= bar_next[i];
      end
    end
  end

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> rd_valid && !err);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> !rd_valid);

  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !legal) |=> err && !rd_valid
      && {cmd_q, sts_q, rom_q, cls_q, lat_q, intl_q}
         == $past({cmd_q, sts_q, rom_q, cls_q, lat_q, intl_q}));

  a_r3_devspec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && legal && !in_hdr) |=> !err
      && {cmd_q, sts_q, rom_q, cls_q, lat_q, intl_q}
         == $past({cmd_q, sts_q, rom_q, cls_q, lat_q, intl_q}));

  a_r6_rom_probe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr4 && req_off == 8'h30 && req_wdata == 32'hFFFF_FFFE) |=> rom_q == 32'hFFFF_FFFF);

  a_r9_dword_cmd_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    (wr4 && req_off == 8'h04) |=> cmd_q == $past(req_wdata[15:0]) && sts_q == $past(sts_q));

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar_chk
    a_r5_type_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((bar_q[g] ^ $past(bar_q[g])) & $past(bar_keep[g])) == 32'h0);
  end
endmodule

// File: tb/pci_cfg_header_tb.sv
`timescale 1ns/1ps
module pci_cfg_header_tb;
  localparam logic [191:0] BINIT = {32'h0, 32'h1, 32'h0, 32'h8, 32'h1, 32'h0};
  localparam logic [191:0] BSIZE = {32'h0, 32'h20, 32'h0, 32'h10000, 32'h100, 32'h1000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_off = '0;
  logic [2:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid, err;
  logic [31:0] rd_data;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m [64];

  always #2 clk = ~clk;

  pci_cfg_header #(
    .VENDOR_ID(16'hC0DE), .DEVICE_ID(16'h7A11), .CMD_INIT(16'h0000), .STATUS_INIT(16'h0010),
    .REVISION(8'h03), .CLASS_CODE(24'h020000), .HDR_TYPE(8'h00), .SUB_VENDOR(16'hC0DE),
    .SUB_ID(16'h0042), .CAP_PTR(8'h00), .ROM_INIT(32'h0), .INT_PIN(8'h01), .MIN_GNT(8'h02),
    .MAX_LAT(8'h08), .NUM_BARS(6), .BAR_INIT(BINIT), .BAR_SIZES(BSIZE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
  );

  function automatic logic [31:0] mword(input int a);
    return {m[a+3], m[a+2], m[a+1], m[a]};
  endfunction

  task automatic mput(input int a, input int n, input logic [31:0] v);
    for (int k = 0; k < n; k++) m[a+k] = v[8*k +: 8];
  endtask

  task automatic model_init();
    for (int i = 0; i < 64; i++) m[i] = 8'h00;
    mput(0, 2, 32'hC0DE); mput(2, 2, 32'h7A11); mput(4, 2, 32'h0); mput(6, 2, 32'h0010);
    m[8] = 8'h03; mput(9, 3, 32'h020000); m[14] = 8'h00;
    for (int n = 0; n < 6; n++) mput(16 + 4*n, 4, BINIT[32*n +: 32]);
    mput(44, 2, 32'hC0DE); mput(46, 2, 32'h0042); mput(48, 4, 32'h0);
    m[61] = 8'h01; m[62] = 8'h02; m[63] = 8'h08;
  endtask

  task automatic model(input bit wr, input int off, input int sz, input logic [31:0] d,
                       output bit e_err, output bit e_rv, output logic [31:0] e_rd);
    bit ok;
    logic [31:0] old, nv, keep;
    ok = (sz == 1 || sz == 2 || sz == 4);
    e_err = !ok; e_rv = ok && !wr; e_rd = '0;
    if (ok && !wr)
      for (int k = 0; k < sz; k++) if (off + k < 64) e_rd[8*k +: 8] = m[off+k];
    if (ok && wr && off < 64) begin
      if (sz == 1) begin
        if (off == 12 || off == 13 || off == 60) m[off] = d[7:0];
        else if (!(off == 8 || off == 11 || off == 61 || off == 62 || off == 63)) e_err = 1;
      end else if (sz == 2) begin
        if (off == 4 || off == 6) mput(off, 2, d);
        else if (off == 12) m[12] = d[7:0];
        else e_err = 1;
      end else begin
        if (off >= 16 && off <= 36 && off % 4 == 0) begin
          old = mword(off);
          keep = old[0] ? 32'h3 : 32'hF;
          nv = (d == 32'hFFFF_FFFF) ? ~(BSIZE[32*((off-16)/4) +: 32] - 1) : d;
          mput(off, 4, (nv & ~keep) | (old & keep));
        end else if (off == 48) mput(48, 4, (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d);
        else if (off == 4) mput(4, 2, d);
      end
    end
  endtask

  task automatic check(input string tag, input bit e_err, input bit e_rv, input logic [31:0] e_rd);
    checks++;
    if (err !== e_err || rd_valid !== e_rv || (e_rv && rd_data !== e_rd)) begin
      failures++;
      $display("FAIL %s off=%h err=%b exp %b rd_valid=%b exp %b rd_data=%h exp %h",
               tag, req_off, err, e_err, rd_valid, e_rv, rd_data, e_rd);
    end
  endtask

  task automatic req(input string tag, input bit wr, input int off, input int sz, input logic [31:0] d);
    bit e_err, e_rv;
    logic [31:0] e_rd;
    model(wr, off, sz, d, e_err, e_rv, e_rd);
    req_valid = 1'b1; req_write = wr; req_off = 8'(off); req_size = 3'(sz); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, e_err, e_rv, e_rd);
  endtask

  task automatic idle(input string tag);
    req_valid = 1'b0;
    @(negedge clk);
    check(tag, 1'b0, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_init();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset outputs quiet");
    // R1: reset contents
    req("R1 ids", 0, 0, 4, 0);
    req("R1 cmd/status", 0, 4, 4, 0);
    req("R1 rev/class", 0, 8, 4, 0);
    req("R1 cls/lat/hdr/bist", 0, 12, 4, 0);
    for (int n = 0; n < 6; n++) req("R1 bar init", 0, 16 + 4*n, 4, 0);
    req("R1 cardbus zero", 0, 40, 4, 0);
    req("R1 subsystem", 0, 44, 4, 0);
    req("R1 rom", 0, 48, 4, 0);
    req("R1 capptr/reserved", 0, 52, 4, 0);
    req("R1 reserved", 0, 56, 4, 0);
    req("R1 int/gnt/lat", 0, 60, 4, 0);
    // R2: sizes and alignment
    req("R2 word odd", 0, 1, 2, 0);
    req("R2 byte", 0, 6, 1, 0);
    req("R2 straddle end", 0, 62, 4, 0);
    idle("R2 idle");
    // R3: device-specific
    req("R3 read 0x40", 0, 64, 4, 0);
    req("R3 read 0xFF", 0, 255, 2, 0);
    req("R3 write ignored", 1, 128, 4, 32'hDEAD_BEEF);
    req("R3 readback", 0, 128, 4, 0);
    req("R3 byte write ignored", 1, 255, 1, 32'hAA);
    // R4: probes
    req("R4 probe bar0", 1, 16, 4, 32'hFFFF_FFFF);
    req("R4 read bar0", 0, 16, 4, 0);
    req("R4 probe bar1 io", 1, 20, 4, 32'hFFFF_FFFF);
    req("R4 read bar1", 0, 20, 4, 0);
    req("R4 probe bar2", 1, 24, 4, 32'hFFFF_FFFF);
    req("R4 read bar2", 0, 24, 4, 0);
    req("R4 probe bar3 size0", 1, 28, 4, 32'hFFFF_FFFF);
    req("R4 read bar3", 0, 28, 4, 0);
    req("R4 probe bar4 io", 1, 32, 4, 32'hFFFF_FFFF);
    req("R4 read bar4", 0, 32, 4, 0);
    // R5: address writes keep type
    req("R5 bar0 write", 1, 16, 4, 32'h1234_5677);
    req("R5 bar0 read", 0, 16, 4, 0);
    req("R5 bar1 write", 1, 20, 4, 32'hABCD_EF02);
    req("R5 bar1 read", 0, 20, 4, 0);
    req("R5 bar2 near probe", 1, 24, 4, 32'hFFFF_FFF0);
    req("R5 bar2 read", 0, 24, 4, 0);
    req("R5 bar5 write", 1, 36, 4, 32'h8000_000F);
    req("R5 bar5 read", 0, 36, 4, 0);
    // back to back: read old, write, read new
    req("R5 b2b read old", 0, 20, 4, 0);
    req("R5 b2b write", 1, 20, 4, 32'h0000_C000);
    req("R5 b2b read new", 0, 20, 4, 0);
    // R6: ROM
    req("R6 rom probe", 1, 48, 4, 32'hFFFF_FFFE);
    req("R6 rom read", 0, 48, 4, 0);
    req("R6 rom write", 1, 48, 4, 32'h000C_0001);
    req("R6 rom b2b read", 0, 48, 4, 0);
    req("R6 rom all ones", 1, 48, 4, 32'hFFFF_FFFF);
    req("R6 rom read2", 0, 48, 4, 0);
    // R7: byte writes
    req("R7 cls", 1, 12, 1, 32'h10);
    req("R7 lat", 1, 13, 1, 32'h40);
    req("R7 intl", 1, 60, 1, 32'h0B);
    req("R7 rev ignored", 1, 8, 1, 32'hFF);
    req("R7 class ignored", 1, 11, 1, 32'hFF);
    req("R7 pin ignored", 1, 61, 1, 32'hFF);
    req("R7 gnt ignored", 1, 62, 1, 32'hFF);
    req("R7 maxlat ignored", 1, 63, 1, 32'hFF);
    req("R7 vendor byte err", 1, 0, 1, 32'h55);
    req("R7 progif byte err", 1, 9, 1, 32'h55);
    req("R7 readback 0x08", 0, 8, 4, 0);
    req("R7 readback 0x0C", 0, 12, 4, 0);
    req("R7 readback 0x3C", 0, 60, 4, 0);
    req("R7 readback 0x00", 0, 0, 4, 0);
    // R8: word writes
    req("R8 cmd", 1, 4, 2, 32'h0007);
    req("R8 status", 1, 6, 2, 32'hA5A0);
    req("R8 cls word", 1, 12, 2, 32'h7720);
    req("R8 readback", 0, 4, 4, 0);
    req("R8 readback cls", 0, 12, 2, 0);
    req("R8 device err", 1, 2, 2, 32'hFFFF);
    req("R8 bar word err", 1, 16, 2, 32'hFFFF);
    req("R8 readback dev", 0, 0, 4, 0);
    // R9: dword command
    req("R9 cmd dword", 1, 4, 4, 32'h9999_0146);
    req("R9 readback", 0, 4, 4, 0);
    req("R9 vendor dword ignored", 1, 0, 4, 32'h1111_2222);
    req("R9 unaligned bar ignored", 1, 17, 4, 32'h3333_4444);
    req("R9 readback ids", 0, 0, 4, 0);
    req("R9 readback bar0", 0, 16, 4, 0);
    // R10: illegal sizes
    req("R10 read size3", 0, 0, 3, 0);
    req("R10 write size0 bar0", 1, 16, 0, 32'hFFFF_FFFF);
    req("R10 write size7 cmd", 1, 4, 7, 32'h0);
    req("R10 write size3 rom", 1, 48, 3, 32'h0);
    idle("R10 pulse ends");
    req("R10 bar0 unchanged", 0, 16, 4, 0);
    req("R10 cmd unchanged", 0, 4, 4, 0);
    req("R10 rom unchanged", 0, 48, 4, 0);
    idle("R2 final idle");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule